// File: doc/BRIEF.md
# Double-Buffered Clocked-Serial Receiver

This block is a serial master that only receives. It derives its own serial clock from the system clock and shifts in one bit per serial clock period from a single data input. It buffers in two stages. A received byte first goes into a holding data register, which the consumer reads. If a further byte finishes while that register is still unread, the shift register keeps the new byte as a second buffer and raises a receive-end flag.

While both stages hold unread bytes, the serial clock stops low, so no incoming bit is lost. A read pulse consumes the byte in the data register. If a byte is waiting in the shift register, the same read moves it forward. Once the enable input is set, bytes arrive back to back for as long as it stays set. When the enable is dropped, the block finishes the byte it is shifting and then stops.

The bit-order and sample-edge mode inputs are expected to stay constant while reception is active.

Top module: `sync_ser_rx`

## Requirements
- R1: After reset, `ready_o` and `rx_end_o` are 0, `sclk_o` is 0, and `rd_data_o` reads 0x00.
- R2: While active, `sclk_o` has a period of DIV system clocks (default 8): low for the first DIV/2 and high for the second DIV/2. When idle or stalled it stays low.
- R3: With `sample_fall_i`=0, `sdi_i` is captured on the rising edge of `sclk_o`. With `sample_fall_i`=1, it is captured on the falling edge.
- R4: With `msb_first_i`=0, the first received bit lands in bit 0 of the byte (LSB first). With `msb_first_i`=1, it lands in bit 7.
- R5: While `enable_i` stays 1 and the consumer keeps up, bytes are received back to back. Rising edges of `sclk_o` stay exactly DIV clocks apart across byte boundaries.
- R6: A completed byte that finds the data register empty is moved into it. `ready_o` is 1 from the next clock on, and `rd_data_o` shows that byte.
- R7: A one-cycle `rd_i` pulse while `ready_o`=1 and `rx_end_o`=0 clears `ready_o`. A pulse while `ready_o`=0 changes neither the flags nor `rd_data_o`.
- R8: A byte that completes while `ready_o`=1 stays in the shift register and sets `rx_end_o`. `rd_data_o` keeps the first byte, and `sclk_o` is held low until a read.
- R9: A read while `rx_end_o`=1 moves the held byte into the data register. In the next cycle `ready_o`=1 and `rx_end_o`=0, and reception continues if `enable_i` is still 1.
- R10: Clearing `enable_i` in the middle of a byte lets that byte finish. Exactly 8 rising edges of `sclk_o` occur for it, and the clock then remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Continuous receive enable |
| msb_first_i | input | 1 | Bit order: 0 LSB first, 1 MSB first |
| sample_fall_i | input | 1 | Sample edge: 0 rising, 1 falling |
| rd_i | input | 1 | One-cycle read strobe for the data register |
| rd_data_o | output | 8 | Data register contents |
| ready_o | output | 1 | Data register holds an unread byte |
| rx_end_o | output | 1 | A second byte waits in the shift register |
| sclk_o | output | 1 | Generated serial clock |
| sdi_i | input | 1 | Serial data input |

## Verification
The bench plays a slave that changes data on the edge opposite the sampling edge. A full sweep of all 256 byte values runs LSB-first with rising-edge sampling. A second full sweep runs MSB-first with falling-edge sampling. The two sweeps separate a swapped bit order, or a wrong sample edge, from correct capture, because either fault shifts or mirrors some of the values. The fixed sequence 0x55, 0x3A, 0xA6 is received with the first byte left unread. This separates direct delivery, the stall with the held second byte, the transfer on read and the resume. A single byte 0x96 with the enable dropped after three clock pulses shows that the clock is neither truncated nor extended.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef struct packed {
    logic rise;  // sclk rises at this edge
    logic fall;  // sclk falls at this edge (end of a bit period)
    logic done;  // last bit period of a byte ends at this edge
  } sclk_evt_t;
endpackage

// File: rtl/srx_sclk_gen.sv
module srx_sclk_gen
  import sync_rx_pkg::*;
#(
  parameter int DIV = 8,
  parameter int W   = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start_ok,
  output logic      sclk_o,
  output sclk_evt_t evt_o
);
  localparam int CW = $clog2(DIV);
  localparam int BW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] HALF_C = CW'(DIV / 2);
  localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);
  localparam logic [BW-1:0] LASTB_C = BW'(W - 1);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic [BW-1:0] bit_q;
  logic          mid, run;

  // mid-byte work is always finished; a new byte starts only when allowed
  assign mid = (cnt_q != '0) || (bit_q != '0);
  assign run = mid || start_ok;

  assign evt_o.rise = run && (cnt_q == HALF_C - 1'b1);
  assign evt_o.fall = run && (cnt_q == LAST_C);
  assign evt_o.done = evt_o.fall && (bit_q == LASTB_C);

  always_comb begin
    cnt_nx = cnt_q;
    if (run) cnt_nx = (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      bit_q  <= '0;
      sclk_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      sclk_o <= (cnt_nx >= HALF_C);
      if (evt_o.fall) bit_q <= (bit_q == LASTB_C) ? '0 : bit_q + 1'b1;
    end
  end

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!mid && !start_ok) |=> !sclk_o);
  // R10
  byte_end_low_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o.done |=> !sclk_o);
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample_stb,
  input  logic         msb_first,
  input  logic         sdi,
  input  logic         hold,
  output logic [W-1:0] sh_q,
  output logic [W-1:0] sh_nx
);
  always_comb begin
    sh_nx = sh_q;
    if (sample_stb)
      sh_nx = msb_first ? {sh_q[W-2:0], sdi} : {sdi, sh_q[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= sh_nx;
  end

  // R8
  held_byte_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && $past(hold)) |-> $stable(sh_q));
endmodule

// File: rtl/srx_buf_ctrl.sv
module srx_buf_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         done,
  input  logic         rd,
  input  logic [W-1:0] byte_in,
  input  logic [W-1:0] sh_q,
  output logic [W-1:0] data_q,
  output logic         ready_q,
  output logic         rx_end_q
);
  logic rd_hit;
  assign rd_hit = rd && ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      ready_q  <= 1'b0;
      rx_end_q <= 1'b0;
    end else begin
      if (rd_hit && rx_end_q) begin
        data_q   <= sh_q;
        rx_end_q <= 1'b0;
      end else if (rd_hit) begin
        ready_q <= 1'b0;
      end
      if (done) begin
        if (!ready_q || rd_hit) begin
          data_q  <= byte_in;
          ready_q <= 1'b1;
        end else begin
          rx_end_q <= 1'b1;
        end
      end
    end
  end

  // R8
  end_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rx_end_q |-> ready_q);
  // R8
  end_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_end_q) |-> $past(ready_q));
  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !rx_end_q && !done) |=> !ready_q);
  // R7
  empty_read_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready_q && !done) |=> ($stable(data_q) && !ready_q));
  // R9
  transfer_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && rx_end_q) |=> (ready_q && !rx_end_q));
endmodule

// File: rtl/sync_ser_rx.sv
module sync_ser_rx
  import sync_rx_pkg::*;
#(
  parameter int DIV = 8,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable_i,
  input  logic         msb_first_i,
  input  logic         sample_fall_i,
  input  logic         rd_i,
  output logic [W-1:0] rd_data_o,
  output logic         ready_o,
  output logic         rx_end_o,
  output logic         sclk_o,
  input  logic         sdi_i
);
  sclk_evt_t    evt;
  logic [W-1:0] sh_q, sh_nx;
  logic         sample_stb;

  srx_sclk_gen #(.DIV(DIV), .W(W)) sclk_gen_i (
    .clk(clk), .rst(rst), .start_ok(enable_i && !rx_end_o),
    .sclk_o(sclk_o), .evt_o(evt));

  assign sample_stb = sample_fall_i ? evt.fall : evt.rise;

  srx_shifter #(.W(W)) shifter_i (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .msb_first(msb_first_i),
    .sdi(sdi_i), .hold(rx_end_o), .sh_q(sh_q), .sh_nx(sh_nx));

  srx_buf_ctrl #(.W(W)) buf_i (
    .clk(clk), .rst(rst), .done(evt.done), .rd(rd_i), .byte_in(sh_nx),
    .sh_q(sh_q), .data_q(rd_data_o), .ready_q(ready_o), .rx_end_q(rx_end_o));

  // R8
  stall_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
    rx_end_o |-> !sclk_o);
endmodule

// File: tb/sync_ser_rx_tb_top.sv
module sync_ser_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0, msb_first = 1'b0, sample_fall = 1'b0, rd = 1'b0;
  logic       sdi = 1'b0;
  logic [7:0] rd_data;
  logic       ready, rx_end, sclk;

  int n_checks = 0, n_fail = 0, cycles = 0;
  int k = 0, nrise = 0, use_sweep = 0;
  logic [7:0] lst [0:3];
  time prev_rise = 0, min_iv = 0, max_iv = 0;
  logic track = 1'b0;

  always #10 clk = ~clk;

  sync_ser_rx dut_i (
    .clk(clk), .rst(rst), .enable_i(enable), .msb_first_i(msb_first),
    .sample_fall_i(sample_fall), .rd_i(rd), .rd_data_o(rd_data),
    .ready_o(ready), .rx_end_o(rx_end), .sclk_o(sclk), .sdi_i(sdi));

  function automatic logic [7:0] byte_at(int j);
    if (use_sweep != 0) return j[7:0];
    return (j < 4) ? lst[j] : 8'h00;
  endfunction

  function automatic logic bit_at(int kk);
    logic [7:0] b;
    int i;
    if (kk < 0) return 1'b0;
    b = byte_at(kk / 8);
    i = kk % 8;
    return msb_first ? b[7 - i] : b[i];
  endfunction

  // slave: change data on the edge opposite the sampling edge
  always @(posedge sclk) begin
    nrise++;
    if (track && prev_rise != 0) begin
      if (min_iv == 0 || $time - prev_rise < min_iv) min_iv = $time - prev_rise;
      if ($time - prev_rise > max_iv) max_iv = $time - prev_rise;
    end
    prev_rise = $time;
    if (sample_fall) begin k++; sdi = bit_at(k); end
  end
  always @(negedge sclk) begin
    if (!sample_fall) begin k++; sdi = bit_at(k); end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic msb, input logic fall);
    @(negedge clk);
    rst = 1'b1; enable = 1'b0; rd = 1'b0;
    msb_first = msb; sample_fall = fall;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    k = fall ? -1 : 0;
    sdi = bit_at(k);
    nrise = 0;
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic wait_ready(input string req);
    int t = 0;
    while (!ready && t < 400) begin @(negedge clk); t++; end
    if (!ready) check(req, 0, 1);
  endtask

  task automatic wait_rx_end(input string req);
    int t = 0;
    while (!rx_end && t < 400) begin @(negedge clk); t++; end
    if (!rx_end) check(req, 0, 1);
  endtask

  task automatic sweep(input logic msb, input logic fall, input string req);
    do_reset(msb, fall);
    use_sweep = 1;
    min_iv = 0; max_iv = 0; prev_rise = 0; track = 1'b1;
    @(negedge clk) enable = 1'b1;
    for (int j = 0; j < 256; j++) begin
      wait_ready(req);
      check(req, rd_data, j);
      pulse_rd();
    end
    enable = 1'b0;
    track = 1'b0;
    // R5: no gaps in the continuous stream
    check("R5", int'(min_iv), 160);
    check("R5", int'(max_iv), 160);
    wait_ready("R10");
    pulse_rd();
    repeat (40) @(negedge clk);
    check("R2", sclk, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    int r0;
    lst[0] = 8'h55; lst[1] = 8'h3A; lst[2] = 8'hA6; lst[3] = 8'h00;

    // R1 reset state
    do_reset(1'b0, 1'b0);
    check("R1", ready, 0);
    check("R1", rx_end, 0);
    check("R1", sclk, 0);
    check("R1", rd_data, 0);

    // R7 read on empty register has no effect
    pulse_rd();
    check("R7", ready, 0);
    check("R7", rd_data, 0);
    repeat (20) @(negedge clk);
    check("R2", nrise, 0);

    // R6 R8 R9 fixed sequence, first byte left unread
    use_sweep = 0;
    do_reset(1'b0, 1'b0);
    min_iv = 0; max_iv = 0; prev_rise = 0; track = 1'b1;
    @(negedge clk) enable = 1'b1;
    wait_ready("R6");
    check("R6", rd_data, 8'h55);
    check("R6", rx_end, 0);
    wait_rx_end("R8");
    track = 1'b0;
    check("R2", int'(min_iv), 160);
    check("R2", int'(max_iv), 160);
    check("R8", ready, 1);
    check("R8", rd_data, 8'h55);
    repeat (60) @(negedge clk);
    check("R8", nrise, 16);
    check("R8", sclk, 0);
    pulse_rd();
    check("R9", rd_data, 8'h3A);
    check("R9", ready, 1);
    check("R9", rx_end, 0);
    repeat (20) @(negedge clk);
    r0 = (nrise > 16) ? 1 : 0;
    check("R9", r0, 1);
    enable = 1'b0;
    wait_rx_end("R9");
    check("R9", rd_data, 8'h3A);
    pulse_rd();
    check("R9", rd_data, 8'hA6);
    pulse_rd();
    check("R7", ready, 0);
    repeat (100) @(negedge clk);
    check("R10", nrise, 24);
    check("R2", sclk, 0);

    // R10 enable dropped mid-byte
    lst[0] = 8'h96;
    do_reset(1'b0, 1'b0);
    @(negedge clk) enable = 1'b1;
    begin
      int t = 0;
      while (nrise < 3 && t < 200) begin @(negedge clk); t++; end
    end
    enable = 1'b0;
    repeat (200) @(negedge clk);
    check("R10", nrise, 8);
    check("R10", ready, 1);
    check("R10", rd_data, 8'h96);
    check("R10", sclk, 0);

    // R3 R4 R5 sweeps of all byte values in both mode pairs
    sweep(1'b0, 1'b0, "R4_lsb_R3_rise");
    sweep(1'b1, 1'b1, "R4_msb_R3_fall");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule